// File: doc/BRIEF.md
# Bit-Serial Subtract-and-Branch Execution Core

This block is the control core of a 16-bit machine whose only instruction subtracts one memory word from another, stores the difference, and branches when the difference is zero or negative. Program words are held in a read-only serial memory, and data words in a read-write serial memory. The core never holds more than one instruction. It asks an external transaction engine for one memory access at a time, names the device, the direction and the word address, and then exchanges the data word one bit per strobe, least significant bit first.

Each instruction occupies word addresses PC, PC+1 and PC+2 of the program memory, holding operand addresses A and B and branch target C. The core computes mem[B] - mem[A] through a one-bit adder as the bits of mem[B] arrive, and it writes the difference back to B. If the difference, read as signed two's complement, is less than or equal to zero, the program counter becomes C. Otherwise it advances by three. A store aimed at one reserved address does not reach memory. Its low byte is instead handed to a transmit UART as a one-cycle load pulse.

Top module: `subleq_seq`

## Requirements
- R1: While `rst` is high, `acc_req` and `uart_valid` are low, and the first access after `rst` falls is a program-memory read of word 0.
- R2: Every instruction issues its accesses in this fixed order: program read at PC, program read at PC+1, data read at A, data read at B, data write at B, and program read at PC+2. `acc_dev` is 1 for program memory and 0 for data memory, and `acc_wr` is 1 only for the write.
- R3: Once `acc_req` rises, `acc_dev`, `acc_wr` and `acc_addr` hold steady until the cycle in which `acc_done` is high, and `acc_req` is low in the cycle after that.
- R4: Data moves one bit for each cycle in which `acc_bit_en` is high while `acc_req` is high, least significant bit first, 16 bits per access. `acc_done` follows in a later cycle than the last bit.
- R5: The word written to B equals mem[B] - mem[A] modulo 2^16, presented on `acc_wdata` least significant bit first.
- R6: When the difference is zero or has its bit 15 set, the next instruction is fetched from address C.
- R7: When the difference is positive, the next instruction is fetched from PC+3.
- R8: When B equals the reserved output address (all ones by default), no write access is issued. `uart_valid` pulses for one cycle with bit 7..0 of the difference on `uart_byte`, while `acc_req` is low, and the sequence continues with the program read at PC+2.
- R9: A reset raised during an access drops `acc_req` at the next clock edge and restarts execution at program word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_req | output | 1 | Access request, held until the transaction engine signals completion |
| acc_dev | output | 1 | Device select: 1 program memory, 0 data memory |
| acc_wr | output | 1 | 1 for a write access, 0 for a read |
| acc_addr | output | 16 | Word address of the access |
| acc_bit_en | input | 1 | One data bit moves in this cycle |
| acc_rdata | input | 1 | Read data bit, valid with `acc_bit_en` |
| acc_wdata | output | 1 | Write data bit for the current bit slot |
| acc_done | input | 1 | Access finished, one cycle after the last bit at the earliest |
| uart_valid | output | 1 | One-cycle load pulse for the transmit UART |
| uart_byte | output | 8 | Byte to transmit, valid with `uart_valid` |

## Verification
An all-zero memory image checks the degenerate loop, in which every difference is zero and the core branches back to word 0 after each instruction. A short program runs through positive, negative, zero and sign-wrapping differences, so a fall-through to PC+3 can be told apart from a taken branch, and an inverted or stuck carry shows up in the written words. The same program stores to the output address twice, which separates a UART load from a memory write. A reset raised in the middle of a bit transfer checks that the access is abandoned and that fetching restarts at word 0 against the memory contents as they stand.

// File: rtl/subleq_pkg.sv
package subleq_pkg;

  // Access slots of one instruction, in issue order.
  typedef enum logic [2:0] {
    PH_FA = 3'd0,   // program word at PC     -> operand address A
    PH_FB = 3'd1,   // program word at PC+1   -> operand address B
    PH_RA = 3'd2,   // data word at A         -> subtrahend
    PH_RB = 3'd3,   // data word at B         -> minuend, subtract on the fly
    PH_WB = 3'd4,   // store difference at B  (or UART load)
    PH_FC = 3'd5    // program word at PC+2   -> branch target C
  } phase_t;

  localparam logic DEV_RAM = 1'b0;
  localparam logic DEV_ROM = 1'b1;

  function automatic phase_t next_phase(input phase_t p);
    case (p)
      PH_FA:   return PH_FB;
      PH_FB:   return PH_RA;
      PH_RA:   return PH_RB;
      PH_RB:   return PH_WB;
      PH_WB:   return PH_FC;
      default: return PH_FA;
    endcase
  endfunction

endpackage

// File: rtl/serial_word_reg.sv
module serial_word_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_en,
  input  logic         rot_en,
  input  logic         din,
  output logic [W-1:0] q
);

  // New bits enter at the top, so after W loads the first bit sits in q[0].
  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (load_en)
      q <= {din, q[W-1:1]};
    else if (rot_en)
      q <= {q[0], q[W-1:1]};
  end

endmodule

// File: rtl/serial_sub_alu.sv
module serial_sub_alu #(
  parameter int W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic step,
  input  logic a_bit,
  input  logic b_bit,
  output logic r_bit,
  output logic leq
);

  logic carry;
  logic nonzero;
  logic sign;

  // b - a = b + ~a + 1, the +1 comes from the preset carry.
  assign r_bit = b_bit ^ ~a_bit ^ carry;
  assign leq   = ~nonzero | sign;

  always_ff @(posedge clk) begin
    if (rst || start) begin
      carry   <= 1'b1;
      nonzero <= 1'b0;
      sign    <= 1'b0;
    end else if (step) begin
      carry   <= (b_bit & ~a_bit) | (b_bit & carry) | (~a_bit & carry);
      nonzero <= nonzero | r_bit;
      sign    <= r_bit;
    end
  end

  // A fresh subtraction starts from an all-zero flag state.
  p_seed_clean_r5: assert property (@(posedge clk) disable iff (rst)
    start |=> (leq && carry));

endmodule

// File: rtl/subleq_ctrl.sv
module subleq_ctrl
  import subleq_pkg::*;
#(
  parameter int           W        = 16,
  parameter logic [W-1:0] OUT_ADDR = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         acc_done,
  input  logic         leq,
  input  logic [W-1:0] a_word,
  input  logic [W-1:0] b_word,
  input  logic [W-1:0] c_word,
  input  logic [7:0]   res_low,
  output phase_t       phase,
  output logic         acc_req,
  output logic         acc_dev,
  output logic         acc_wr,
  output logic [W-1:0] acc_addr,
  output logic         uart_valid,
  output logic [7:0]   uart_byte
);

  localparam logic [W-1:0] OFS_B    = W'(1);
  localparam logic [W-1:0] OFS_C    = W'(2);
  localparam logic [W-1:0] INSN_LEN = W'(3);

  logic [W-1:0] pc;
  logic [W-1:0] launch_addr;
  logic         launch_dev;
  logic         out_hit;
  logic         finish_c;

  assign out_hit  = (b_word == OUT_ADDR);
  assign finish_c = (phase == PH_FC) && acc_req && acc_done;

  always_comb begin
    case (phase)
      PH_FA:   begin launch_addr = pc;         launch_dev = DEV_ROM; end
      PH_FB:   begin launch_addr = pc + OFS_B; launch_dev = DEV_ROM; end
      PH_RA:   begin launch_addr = a_word;     launch_dev = DEV_RAM; end
      PH_RB:   begin launch_addr = b_word;     launch_dev = DEV_RAM; end
      PH_WB:   begin launch_addr = b_word;     launch_dev = DEV_RAM; end
      PH_FC:   begin launch_addr = pc + OFS_C; launch_dev = DEV_ROM; end
      default: begin launch_addr = pc;         launch_dev = DEV_ROM; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_FA;
      pc         <= '0;
      acc_req    <= 1'b0;
      acc_dev    <= DEV_ROM;
      acc_wr     <= 1'b0;
      acc_addr   <= '0;
      uart_valid <= 1'b0;
      uart_byte  <= '0;
    end else begin
      uart_valid <= 1'b0;
      if (!acc_req) begin
        if (phase == PH_WB && out_hit) begin
          uart_valid <= 1'b1;
          uart_byte  <= res_low;
          phase      <= PH_FC;
        end else begin
          acc_req  <= 1'b1;
          acc_dev  <= launch_dev;
          acc_wr   <= (phase == PH_WB);
          acc_addr <= launch_addr;
        end
      end else if (acc_done) begin
        acc_req <= 1'b0;
        phase   <= next_phase(phase);
        if (phase == PH_FC)
          pc <= leq ? c_word : pc + INSN_LEN;
      end
    end
  end

  // R6/R7: the new PC is either the fetched target or the fall-through.
  p_pc_next_r6: assert property (@(posedge clk) disable iff (rst)
    finish_c |=> ((pc == $past(c_word)) || (pc == $past(pc) + INSN_LEN)));

  p_pc_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !finish_c |=> $stable(pc));

  // R8: the reserved address never becomes a memory store.
  p_out_no_store_r8: assert property (@(posedge clk) disable iff (rst)
    (acc_req && acc_wr) |-> (acc_addr != OUT_ADDR));

endmodule

// File: rtl/subleq_seq.sv
module subleq_seq
  import subleq_pkg::*;
#(
  parameter int                WORD_W   = 16,
  parameter logic [WORD_W-1:0] OUT_ADDR = '1
) (
  input  logic              clk,
  input  logic              rst,
  output logic              acc_req,
  output logic              acc_dev,
  output logic              acc_wr,
  output logic [WORD_W-1:0] acc_addr,
  input  logic              acc_bit_en,
  input  logic              acc_rdata,
  output logic              acc_wdata,
  input  logic              acc_done,
  output logic              uart_valid,
  output logic [7:0]        uart_byte
);

  localparam int N_FIELDS = 3;

  phase_t            phase;
  logic              xfer;
  logic [WORD_W-1:0] field_q [N_FIELDS];
  logic [WORD_W-1:0] opa_q;
  logic [WORD_W-1:0] res_q;
  logic              r_bit;
  logic              leq;
  logic              alu_start;
  logic              spare_bits_unused;

  assign xfer      = acc_req && acc_bit_en;
  assign alu_start = (phase == PH_RA) && acc_req && acc_done;
  assign acc_wdata = res_q[0];
  assign spare_bits_unused = ^{opa_q[WORD_W-1:1], res_q[WORD_W-1:8]};

  // Instruction fields A, B, C: one serial register per program fetch.
  for (genvar k = 0; k < N_FIELDS; k++) begin : g_field
    localparam phase_t FILL_PH = (k == 0) ? PH_FA : ((k == 1) ? PH_FB : PH_FC);
    serial_word_reg #(.W(WORD_W)) u_field (
      .clk     (clk),
      .rst     (rst),
      .load_en (xfer && (phase == FILL_PH)),
      .rot_en  (1'b0),
      .din     (acc_rdata),
      .q       (field_q[k])
    );
  end

  // Subtrahend: loaded during the read of A, replayed during the read of B.
  serial_word_reg #(.W(WORD_W)) u_opa (
    .clk     (clk),
    .rst     (rst),
    .load_en (xfer && (phase == PH_RA)),
    .rot_en  (xfer && (phase == PH_RB)),
    .din     (acc_rdata),
    .q       (opa_q)
  );

  // Difference: built during the read of B, replayed during the store.
  serial_word_reg #(.W(WORD_W)) u_res (
    .clk     (clk),
    .rst     (rst),
    .load_en (xfer && (phase == PH_RB)),
    .rot_en  (xfer && (phase == PH_WB)),
    .din     (r_bit),
    .q       (res_q)
  );

  serial_sub_alu #(.W(WORD_W)) u_alu (
    .clk   (clk),
    .rst   (rst),
    .start (alu_start),
    .step  (xfer && (phase == PH_RB)),
    .a_bit (opa_q[0]),
    .b_bit (acc_rdata),
    .r_bit (r_bit),
    .leq   (leq)
  );

  subleq_ctrl #(.W(WORD_W), .OUT_ADDR(OUT_ADDR)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .acc_done   (acc_done),
    .leq        (leq),
    .a_word     (field_q[0]),
    .b_word     (field_q[1]),
    .c_word     (field_q[2]),
    .res_low    (res_q[7:0]),
    .phase      (phase),
    .acc_req    (acc_req),
    .acc_dev    (acc_dev),
    .acc_wr     (acc_wr),
    .acc_addr   (acc_addr),
    .uart_valid (uart_valid),
    .uart_byte  (uart_byte)
  );

  p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (acc_req && !acc_done) |=>
      (acc_req && $stable(acc_addr) && $stable(acc_dev) && $stable(acc_wr)));

  p_req_drop_r3: assert property (@(posedge clk) disable iff (rst)
    (acc_req && acc_done) |=> !acc_req);

  p_write_ram_only_r2: assert property (@(posedge clk) disable iff (rst)
    (acc_req && acc_wr) |-> (acc_dev == DEV_RAM));

  p_uart_bus_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    uart_valid |-> !acc_req);

  p_uart_single_r8: assert property (@(posedge clk) disable iff (rst)
    uart_valid |=> !uart_valid);

  // ALU flags must agree with the stored difference once B is consumed.
  p_flag_match_r6: assert property (@(posedge clk) disable iff (rst)
    ((phase == PH_RB) && acc_req && acc_done) |->
      (leq == ((res_q == '0) || res_q[WORD_W-1])));

  p_reset_idle_r9: assert property (@(posedge clk)
    rst |=> !acc_req);

endmodule

// File: tb/subleq_seq_bench.sv
`timescale 1ns/1ps
module subleq_seq_bench;

  typedef struct {
    bit          is_uart;
    bit          dev;
    bit          wr;
    logic [15:0] addr;
    logic [15:0] data;
    string       tag;
  } ev_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_req, acc_dev, acc_wr, acc_wdata;
  logic [15:0] acc_addr;
  logic        acc_bit_en = 1'b0;
  logic        acc_rdata  = 1'b0;
  logic        acc_done   = 1'b0;
  logic        uart_valid;
  logic [7:0]  uart_byte;

  logic [15:0] rom     [256];
  logic [15:0] ram     [256];
  logic [15:0] ref_ram [256];
  ev_t         exp_q [$];

  int n_cmp = 0;
  int n_bad = 0;
  bit in_xfer = 0;
  int bit_idx = 0;
  int xfer_no = 0;

  always #10 clk = ~clk;

  subleq_seq u_subleq_seq (
    .clk(clk), .rst(rst),
    .acc_req(acc_req), .acc_dev(acc_dev), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .acc_bit_en(acc_bit_en), .acc_rdata(acc_rdata), .acc_wdata(acc_wdata),
    .acc_done(acc_done), .uart_valid(uart_valid), .uart_byte(uart_byte)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic push(input bit u, input bit d, input bit w, input logic [15:0] a,
                      input logic [15:0] v, input string t);
    ev_t e;
    e.is_uart = u; e.dev = d; e.wr = w; e.addr = a; e.data = v; e.tag = t;
    exp_q.push_back(e);
  endtask

  // Driver: reference execution of n instructions from word 0.
  task automatic plan(input int n);
    logic [15:0] pc, a, b, c, r, p1, p2;
    string ftag;
    pc = 16'd0;
    ftag = "R1";
    for (int k = 0; k < n; k++) begin
      p1 = pc + 16'd1;
      p2 = pc + 16'd2;
      a = rom[pc[7:0]];
      b = rom[p1[7:0]];
      c = rom[p2[7:0]];
      push(0, 1, 0, pc, 16'd0, ftag);
      push(0, 1, 0, p1, 16'd0, "R2");
      push(0, 0, 0, a,  16'd0, "R4");
      push(0, 0, 0, b,  16'd0, "R2");
      r = ref_ram[b[7:0]] - ref_ram[a[7:0]];
      if (b == 16'hFFFF) begin
        push(1, 0, 0, 16'd0, {8'd0, r[7:0]}, "R8");
      end else begin
        push(0, 0, 1, b, r, "R5");
        ref_ram[b[7:0]] = r;
      end
      push(0, 1, 0, p2, 16'd0, "R2");
      if ($signed(r) <= 16'sd0) begin
        pc = c;       ftag = "R6";
      end else begin
        pc = pc + 16'd3; ftag = "R7";
      end
    end
  endtask

  // Transaction engine model with scoreboard monitor for accesses.
  initial begin
    bit s_dev, s_wr, aborted, stable_ok;
    logic [15:0] s_addr, word, wcap;
    ev_t e;
    forever begin
      @(negedge clk);
      if (!rst && acc_req) begin
        s_dev = acc_dev; s_wr = acc_wr; s_addr = acc_addr;
        word = s_dev ? rom[s_addr[7:0]] : ram[s_addr[7:0]];
        wcap = '0; aborted = 0; stable_ok = 1;
        in_xfer = 1; xfer_no++;
        for (int i = 0; i < 16; i++) begin
          if (i > 0) @(negedge clk);
          if (rst) begin aborted = 1; break; end
          if (!acc_req || acc_addr != s_addr || acc_dev != s_dev || acc_wr != s_wr)
            stable_ok = 0;
          wcap[i] = acc_wdata;
          acc_bit_en = 1'b1;
          acc_rdata = word[i];
          bit_idx = i;
        end
        if (!aborted) begin
          @(negedge clk);
          acc_bit_en = 1'b0;
          if (rst) aborted = 1;
        end
        if (aborted) begin
          acc_bit_en = 1'b0;
          acc_done = 1'b0;
        end else begin
          acc_done = 1'b1;
          check(stable_ok, "R3", "request fields held", {15'd0, s_dev, s_addr}, {15'd0, s_dev, s_addr});
          if (s_wr) ram[s_addr[7:0]] = wcap;
          if (exp_q.size() == 0) begin
            check(0, "R2", "unexpected access", {14'd0, s_dev, s_wr, s_addr}, 32'd0);
          end else begin
            e = exp_q.pop_front();
            check(!e.is_uart && e.dev == s_dev && e.wr == s_wr && e.addr == s_addr, e.tag,
                  "access dev/wr/addr", {14'd0, s_dev, s_wr, s_addr},
                  {13'd0, e.is_uart, e.dev, e.wr, e.addr});
            if (s_wr)
              check(wcap == e.data, e.tag, "write data", {16'd0, wcap}, {16'd0, e.data});
          end
          @(negedge clk);
          acc_done = 1'b0;
        end
        in_xfer = 0;
      end
    end
  end

  // Monitor for UART loads.
  always @(negedge clk) begin
    ev_t e;
    if (!rst && uart_valid) begin
      if (exp_q.size() == 0) begin
        check(0, "R8", "unexpected uart load", {24'd0, uart_byte}, 32'd0);
      end else begin
        e = exp_q.pop_front();
        check(e.is_uart && e.data[7:0] == uart_byte, e.tag, "uart byte",
              {23'd0, 1'b1, uart_byte}, {23'd0, e.is_uart, e.data[7:0]});
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "R2", "watchdog expired", 32'd0, 32'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  task automatic run_to_empty();
    @(negedge clk);
    rst = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin rom[i] = '0; ram[i] = '0; ref_ram[i] = '0; end

    // R1: idle outputs while reset is held.
    repeat (3) @(negedge clk);
    check(acc_req == 1'b0, "R1", "acc_req in reset", {31'd0, acc_req}, 32'd0);
    check(uart_valid == 1'b0, "R1", "uart_valid in reset", {31'd0, uart_valid}, 32'd0);

    // Pattern 1: all-zero memories, every difference is zero.
    plan(3);
    run_to_empty();

    // Pattern 2: mixed signs, sign wrap and output-address stores.
    rom[0]  = 16'd10; rom[1]  = 16'd11;     rom[2]  = 16'd9;
    rom[3]  = 16'd10; rom[4]  = 16'd11;     rom[5]  = 16'd12;
    rom[9]  = 16'd20; rom[10] = 16'd21;     rom[11] = 16'd0;
    rom[12] = 16'd12; rom[13] = 16'hFFFF;   rom[14] = 16'd15;
    rom[15] = 16'd13; rom[16] = 16'd14;     rom[17] = 16'd0;
    ram[10] = 16'd3;  ram[11] = 16'd5;      ram[12] = 16'h1041;
    ram[13] = 16'd7;  ram[14] = 16'd7;      ram[20] = 16'h8000;
    ram[21] = 16'h0001; ram[255] = 16'h0000;
    for (int i = 0; i < 256; i++) ref_ram[i] = ram[i];
    plan(12);
    run_to_empty();

    // Pattern 3: reset in the middle of an access (R9).
    for (int i = 0; i < 256; i++) ref_ram[i] = ram[i];
    plan(2);
    xfer_no = 0;
    @(negedge clk);
    rst = 1'b0;
    do @(posedge clk); while (!(in_xfer && xfer_no == 3 && bit_idx >= 5));
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(acc_req == 1'b0, "R9", "request after mid-access reset", {31'd0, acc_req}, 32'd0);
    repeat (2) @(negedge clk);
    exp_q.delete();
    for (int i = 0; i < 256; i++) ref_ram[i] = ram[i];
    plan(4);
    run_to_empty();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule